// File: doc/BRIEF.md
# Processor I/O Port Strobe Unit

This block is the I/O execution stage of a small 8-bit processor core. The instruction decoder hands it one command at a time. A command carries an operation type, a port number, the value of a source register, an 8-bit constant and a destination register index. The unit runs each command as a two-cycle instruction. In the issue cycle it registers the port identifier and the output data. In the execute cycle it raises exactly one single-cycle strobe: a read strobe for an input, a write strobe for an output, or a constant-write strobe for a constant output.

For an input, the byte on the input bus is sampled in the execute cycle. That byte is handed to the register file in the next cycle, with a write enable and the destination index. For a constant output, only the low four bits of the port number select the destination, so the unit drives the upper four bits of the port identifier to zero.

A sleep input stops the unit. An instruction that is already in its execute cycle finishes first. After that the unit accepts no command and raises no strobe until sleep is released.

Top module: `io_strobe_unit`

## Requirements
- R1: While `rst` is high and on the first cycle after reset, all strobes and `rf_we` are low and `port_id`, `out_data`, `rf_wdata` and `rf_waddr` are zero.
- R2: A command is accepted when the unit is idle, `sleep` is low, `cmd_valid` is high and `cmd_op` is not 2'b00. In the following cycle exactly the strobe that matches the operation is high for one cycle: 2'b01 input gives `rd_stb`, 2'b10 output gives `wr_stb`, 2'b11 constant output gives `kwr_stb`.
- R3: During `wr_stb`, `port_id` equals the accepted `cmd_port` and `out_data` equals the accepted `cmd_data`.
- R4: During `kwr_stb`, `port_id[3:0]` equals the accepted `cmd_port[3:0]`, `port_id[7:4]` is zero and `out_data` equals the accepted `cmd_kdata`.
- R5: During `rd_stb`, `port_id` equals the accepted `cmd_port`. In the next cycle `rf_we` is high for one cycle, `rf_wdata` holds the `in_data` value sampled in the strobe cycle and `rf_waddr` holds the accepted `cmd_dst`. In every other cycle `rf_we` is low.
- R6: At most one strobe is high in any cycle. A command presented in the execute cycle of another command is ignored and produces no strobe.
- R7: `port_id` and `out_data` change only in the cycle after an accepted command. An input command leaves `out_data` unchanged.
- R8: If `sleep` is high while the unit is idle, the command present in that cycle is ignored. No strobe is raised from the next cycle until one cycle after `sleep` is sampled low. A command can be accepted in that cycle.
- R9: If `sleep` is high during an execute cycle, that cycle's strobe (and any resulting `rf_we`) still completes, and the unit then sleeps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 1 | Sleep request, active high |
| cmd_valid | input | 1 | Command present from the decoder |
| cmd_op | input | 2 | 00 none, 01 input, 10 output, 11 constant output |
| cmd_port | input | 8 | Port number |
| cmd_data | input | 8 | Source register value for output |
| cmd_kdata | input | 8 | Constant for constant output |
| cmd_dst | input | 4 | Destination register for input |
| in_data | input | 8 | Input bus from peripherals |
| port_id | output | 8 | Port identifier |
| out_data | output | 8 | Output data bus |
| rd_stb | output | 1 | Input strobe |
| wr_stb | output | 1 | Output strobe |
| kwr_stb | output | 1 | Constant-output strobe |
| rf_we | output | 1 | Register file write enable |
| rf_wdata | output | 8 | Captured input byte |
| rf_waddr | output | 4 | Destination register index |

## Verification
The hardest situations to reach are the timing collisions. One is sleep rising in exactly the execute cycle of an instruction. The other is a new command arriving while the previous one is still executing. Neither occurs if the decoder waits politely. The stimulus therefore issues a command and raises sleep on the following edge. It also holds `cmd_valid` high for several cycles with changing operations. A long random phase then mixes both with sleep toggling, and every cycle is compared against a behavioural model.

// File: rtl/iostb_pkg.sv
package iostb_pkg;
    localparam int DATA_W  = 8;
    localparam int PORT_W  = 8;
    localparam int KPORT_W = 4;
    localparam int RADDR_W = 4;
    localparam int NUM_STB = 3;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_IN   = 2'd1,
        OP_OUT  = 2'd2,
        OP_KOUT = 2'd3
    } io_op_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_EXEC  = 2'd1,
        PH_SLEEP = 2'd2
    } io_phase_e;

    typedef struct packed {
        io_op_e              op;
        logic [PORT_W-1:0]   port;
        logic [DATA_W-1:0]   data;
        logic [DATA_W-1:0]   kdata;
    } io_cmd_t;

    typedef struct packed {
        logic rd;
        logic wr;
        logic kwr;
    } io_stb_t;

    // Constant outputs address only the low port bits; the rest read as zero.
    function automatic logic [PORT_W-1:0] kport_map(input logic [PORT_W-1:0] p);
        logic [PORT_W-1:0] r;
        r = '0;
        r[KPORT_W-1:0] = p[KPORT_W-1:0];
        return r;
    endfunction
endpackage

// File: rtl/io_seq.sv
module io_seq
    import iostb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sleep,
    input  logic      cmd_valid,
    input  io_op_e    cmd_op,
    output logic      accept,
    output logic      exec,
    output io_phase_e phase
);
    io_phase_e phase_d;

    always_comb begin
        accept  = (phase == PH_IDLE) && !sleep && cmd_valid && (cmd_op != OP_NONE);
        exec    = (phase == PH_EXEC);
        phase_d = phase;
        unique case (phase)
            PH_IDLE: begin
                if (sleep)       phase_d = PH_SLEEP;
                else if (accept) phase_d = PH_EXEC;
            end
            PH_EXEC:  phase_d = sleep ? PH_SLEEP : PH_IDLE;
            PH_SLEEP: if (!sleep) phase_d = PH_IDLE;
            default:  phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= phase_d;
    end

    a_r2_exec_single: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC) |=> (phase != PH_EXEC));
    a_r8_idle_to_sleep: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && sleep) |=> (phase == PH_SLEEP));
    a_r9_finish_then_sleep: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && sleep) |=> (phase == PH_SLEEP));
endmodule

// File: rtl/io_bus_drv.sv
module io_bus_drv
    import iostb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              exec,
    input  io_cmd_t           cmd,
    output logic [PORT_W-1:0] port_id,
    output logic [DATA_W-1:0] out_data,
    output io_stb_t           stb
);
    io_op_e             op_q;
    logic [NUM_STB-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q     <= OP_NONE;
            port_id  <= '0;
            out_data <= '0;
        end else if (accept) begin
            op_q    <= cmd.op;
            port_id <= (cmd.op == OP_KOUT) ? kport_map(cmd.port) : cmd.port;
            if (cmd.op == OP_OUT)  out_data <= cmd.data;
            if (cmd.op == OP_KOUT) out_data <= cmd.kdata;
        end
    end

    // One decode lane per strobe kind; lane g fires for operation code g+1.
    for (genvar g = 0; g < NUM_STB; g++) begin : g_lane
        assign hit[g] = exec && (op_q == io_op_e'(2'(g + 1)));
    end

    always_comb begin
        stb.rd  = hit[0];
        stb.wr  = hit[1];
        stb.kwr = hit[2];
    end

    a_r6_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({stb.rd, stb.wr, stb.kwr}));
    a_r2_pulse_width: assert property (@(posedge clk) disable iff (rst)
        (|hit) |=> !(|hit));
    a_r4_khi_zero: assert property (@(posedge clk) disable iff (rst)
        stb.kwr |-> (port_id[PORT_W-1:KPORT_W] == '0));
    a_r7_hold_after: assert property (@(posedge clk) disable iff (rst)
        (|hit) |=> ($stable(port_id) && $stable(out_data)));
endmodule

// File: rtl/io_capture.sv
module io_capture
    import iostb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               accept,
    input  logic [RADDR_W-1:0] cmd_dst,
    input  logic               rd_stb,
    input  logic [DATA_W-1:0]  in_data,
    output logic               rf_we,
    output logic [DATA_W-1:0]  rf_wdata,
    output logic [RADDR_W-1:0] rf_waddr
);
    logic [RADDR_W-1:0] dst_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            dst_q    <= '0;
            rf_we    <= 1'b0;
            rf_wdata <= '0;
            rf_waddr <= '0;
        end else begin
            if (accept) dst_q <= cmd_dst;
            rf_we <= rd_stb;
            if (rd_stb) begin
                rf_wdata <= in_data;
                rf_waddr <= dst_q;
            end
        end
    end

    a_r5_capture: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> (rf_we && rf_wdata == $past(in_data)));
    a_r5_we_only_after_read: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> $past(rd_stb));
endmodule

// File: rtl/io_strobe_unit.sv
module io_strobe_unit
    import iostb_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sleep,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [PORT_W-1:0]  cmd_port,
    input  logic [DATA_W-1:0]  cmd_data,
    input  logic [DATA_W-1:0]  cmd_kdata,
    input  logic [RADDR_W-1:0] cmd_dst,
    input  logic [DATA_W-1:0]  in_data,
    output logic [PORT_W-1:0]  port_id,
    output logic [DATA_W-1:0]  out_data,
    output logic               rd_stb,
    output logic               wr_stb,
    output logic               kwr_stb,
    output logic               rf_we,
    output logic [DATA_W-1:0]  rf_wdata,
    output logic [RADDR_W-1:0] rf_waddr
);
    io_cmd_t   cmd;
    io_stb_t   stb;
    io_phase_e phase;
    logic      accept;
    logic      exec;

    always_comb begin
        cmd.op    = io_op_e'(cmd_op);
        cmd.port  = cmd_port;
        cmd.data  = cmd_data;
        cmd.kdata = cmd_kdata;
    end

    io_seq u_seq (
        .clk(clk), .rst(rst), .sleep(sleep), .cmd_valid(cmd_valid),
        .cmd_op(cmd.op), .accept(accept), .exec(exec), .phase(phase)
    );

    io_bus_drv u_bus (
        .clk(clk), .rst(rst), .accept(accept), .exec(exec), .cmd(cmd),
        .port_id(port_id), .out_data(out_data), .stb(stb)
    );

    assign rd_stb  = stb.rd;
    assign wr_stb  = stb.wr;
    assign kwr_stb = stb.kwr;

    io_capture u_cap (
        .clk(clk), .rst(rst), .accept(accept), .cmd_dst(cmd_dst),
        .rd_stb(rd_stb), .in_data(in_data), .rf_we(rf_we),
        .rf_wdata(rf_wdata), .rf_waddr(rf_waddr)
    );

    a_r8_quiet_asleep: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SLEEP) |-> !(rd_stb || wr_stb || kwr_stb));
endmodule

// File: tb/io_strobe_unit_tb_top.sv
`timescale 1ns/1ps
module io_strobe_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sleep = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [7:0] cmd_port = 8'd0, cmd_data = 8'd0, cmd_kdata = 8'd0, in_data = 8'd0;
    logic [3:0] cmd_dst = 4'd0;
    logic [7:0] port_id, out_data, rf_wdata;
    logic       rd_stb, wr_stb, kwr_stb, rf_we;
    logic [3:0] rf_waddr;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_tag = "R1";

    always #2.5 clk = ~clk;

    io_strobe_unit dut_i (
        .clk(clk), .rst(rst), .sleep(sleep), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_port(cmd_port), .cmd_data(cmd_data), .cmd_kdata(cmd_kdata), .cmd_dst(cmd_dst),
        .in_data(in_data), .port_id(port_id), .out_data(out_data), .rd_stb(rd_stb),
        .wr_stb(wr_stb), .kwr_stb(kwr_stb), .rf_we(rf_we), .rf_wdata(rf_wdata),
        .rf_waddr(rf_waddr)
    );

    // Behavioural reference: 0 idle, 1 executing, 2 asleep
    int       m_ph = 0;
    int       m_op = 0;
    int       m_pid = 0, m_out = 0, m_dst = 0;
    int       m_we = 0, m_wd = 0, m_wa = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_ph <= 0; m_op <= 0; m_pid <= 0; m_out <= 0; m_dst <= 0;
            m_we <= 0; m_wd <= 0; m_wa <= 0;
        end else begin
            m_we <= (m_ph == 1 && m_op == 1) ? 1 : 0;
            if (m_ph == 1 && m_op == 1) begin
                m_wd <= int'(in_data);
                m_wa <= m_dst;
            end
            if (m_ph == 0) begin
                if (sleep) m_ph <= 2;
                else if (cmd_valid && cmd_op != 2'd0) begin
                    m_ph  <= 1;
                    m_op  <= int'(cmd_op);
                    m_dst <= int'(cmd_dst);
                    m_pid <= (cmd_op == 2'd3) ? int'(cmd_port) % 16 : int'(cmd_port);
                    if (cmd_op == 2'd2) m_out <= int'(cmd_data);
                    if (cmd_op == 2'd3) m_out <= int'(cmd_kdata);
                end
            end else if (m_ph == 1) begin
                m_ph <= sleep ? 2 : 0;
            end else if (!sleep) begin
                m_ph <= 0;
            end
        end
    end

    task automatic chk(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            chk("rd_stb",   int'(rd_stb),  (m_ph == 1 && m_op == 1) ? 1 : 0);
            chk("wr_stb",   int'(wr_stb),  (m_ph == 1 && m_op == 2) ? 1 : 0);
            chk("kwr_stb",  int'(kwr_stb), (m_ph == 1 && m_op == 3) ? 1 : 0);
            chk("port_id",  int'(port_id), m_pid);
            chk("out_data", int'(out_data), m_out);
            chk("rf_we",    int'(rf_we),   m_we);
            chk("rf_wdata", int'(rf_wdata), m_wd);
            chk("rf_waddr", int'(rf_waddr), m_wa);
            in_data <= 8'($urandom);
        end
    end

    task automatic issue(input logic [1:0] op, input logic [7:0] p, input logic [7:0] d,
                         input logic [7:0] k, input logic [3:0] dst);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_port = p; cmd_data = d; cmd_kdata = k; cmd_dst = dst;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 2'd0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cur_tag = "R1";
        idle(3);
        rst = 1'b0;
        idle(2);
        cur_tag = "R3";
        issue(2'd2, 8'hA5, 8'h3C, 8'h00, 4'd0); idle(2);
        cur_tag = "R4";
        issue(2'd3, 8'hF7, 8'h11, 8'h9E, 4'd0); idle(2);
        cur_tag = "R5";
        issue(2'd1, 8'h42, 8'h77, 8'h55, 4'd9); idle(3);
        cur_tag = "R7";
        issue(2'd2, 8'h10, 8'hC3, 8'h00, 4'd2);
        issue(2'd1, 8'h20, 8'hFF, 8'hFF, 4'd7); idle(3);
        cur_tag = "R6";
        @(negedge clk);
        cmd_valid = 1'b1;
        for (int i = 0; i < 8; i++) begin
            cmd_op = 2'(1 + (i % 3)); cmd_port = 8'(8'hE0 + i); cmd_data = 8'(i * 17);
            cmd_kdata = 8'(8'h80 + i); cmd_dst = 4'(i);
            @(negedge clk);
        end
        cmd_valid = 1'b0; cmd_op = 2'd0; idle(2);
        cur_tag = "R8";
        sleep = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_port = 8'h33; cmd_data = 8'h44;
        idle(5);
        sleep = 1'b0;
        idle(3);
        cmd_valid = 1'b0; cmd_op = 2'd0; idle(2);
        cur_tag = "R9";
        issue(2'd1, 8'h5A, 8'h00, 8'h00, 4'd12);
        sleep = 1'b1;
        issue(2'd3, 8'h9C, 8'h00, 8'h66, 4'd1);
        idle(3);
        sleep = 1'b0; idle(3);
        cur_tag = "R2";
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            cmd_valid = ($urandom % 3) != 0;
            cmd_op = 2'($urandom); cmd_port = 8'($urandom); cmd_data = 8'($urandom);
            cmd_kdata = 8'($urandom); cmd_dst = 4'($urandom);
            sleep = ($urandom % 8) == 0;
        end
        cmd_valid = 1'b0; sleep = 1'b0; idle(4);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule